// File: doc/BRIEF.md
# Pipelined Complex Preamble Correlator

This block measures how closely the incoming complex baseband stream matches a known preamble segment. A receiver uses this to find frame timing. One signed complex sample enters on every clock. The block multiplies each sample by a fixed table of complex-conjugated preamble coefficients and adds the products along a transposed direct-form chain. Every cycle it produces the correlation over the most recent `TAPS` samples.

The same input sample goes to every tap at once. Each tap is a complex multiplier followed by an adder, and the adder feeds a register that passes its partial sum to the next tap. Every tap has five register stages:

- two input alignment registers;
- the four real partial products;
- the complex combine;
- the accumulate.

Because of this, the delay from an input sample to its window result is a fixed number of cycles. A flag marks the first complete window. A squared-magnitude metric can also be produced one cycle after the correlation; it is enabled by parameter.

Top module: `preamble_xcorr`

## Requirements
- R1: The coefficient for tap k (k = 0 is paired with the oldest sample of the window) is c[k] = (((29k+5) mod 251) − 125) + j·(((53k+17) mod 241) − 120), truncated to `CW` signed bits per part. These stored values are already conjugated.
- R2: For the window ending at sample n, the correlation is y[n] = Σ_{k=0}^{TAPS−1} c[k]·x[n−TAPS+1+k]. Each complex product is formed as re = xr·cr − xi·ci and im = xr·ci + xi·cr. The arithmetic is exact signed arithmetic.
- R3: The window that ends with the sample captured at rising edge n appears on `corr_re`/`corr_im` just after rising edge n+4.
- R4: Count the first rising edge with `rst` low as edge 0. `corr_valid` is low until edge TAPS+3 and rises at that edge. It then stays high until the next reset.
- R5: When `MAG_EN` is 1, `mag` equals corr_re² + corr_im² of the correlation presented one cycle earlier. `mag_valid` follows `corr_valid` with a one-cycle delay.
- R6: The accumulator width is `DW + CW + 1 + clog2(TAPS)`. Full-scale inputs of either sign yield the exact sum with no wrap.
- R7: A synchronous reset clears every pipeline register, every partial sum, both outputs and both valid flags. After reset no earlier sample contributes to any result flagged valid.
- R8: A single unit sample (1 + 0j) in an otherwise zero stream produces c[TAPS−1], c[TAPS−2], …, c[0] on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_re | input | DW | Received sample, real part, signed |
| rx_im | input | DW | Received sample, imaginary part, signed |
| corr_re | output | AW | Correlation sum, real part, signed |
| corr_im | output | AW | Correlation sum, imaginary part, signed |
| corr_valid | output | 1 | Correlation covers a complete window |
| mag | output | 2·AW | Squared magnitude of the correlation, unsigned |
| mag_valid | output | 1 | `mag` is meaningful |

## Verification
The bench builds the block with `TAPS = 8`, `DW = 8`, `CW = 8` and the magnitude stage enabled. The short chain fills in a dozen cycles, so the valid edge, a unit impulse walking through every tap, and several full windows all fit in a short run. With only eight taps, a stream of full-scale samples drives the 20-bit accumulator to its largest reachable values. Those samples are the most negative codes in both parts, and then mixed-sign extremes. A reset in the middle of a stream shows that stale partial sums never reach a result flagged valid.

// File: rtl/preamble_xcorr.sv
module preamble_xcorr #(
  parameter int TAPS   = 64,
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter bit MAG_EN = 1'b1,
  localparam int AW    = DW + CW + 1 + $clog2(TAPS),
  localparam int MW    = 2 * AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] rx_re,
  input  logic signed [DW-1:0] rx_im,
  output logic signed [AW-1:0] corr_re,
  output logic signed [AW-1:0] corr_im,
  output logic                 corr_valid,
  output logic        [MW-1:0] mag,
  output logic                 mag_valid
);
  localparam int PW   = DW + CW;
  localparam int QW   = PW + 1;
  localparam int FILL = TAPS + 3;
  localparam int NW   = $clog2(FILL + 1);

  function automatic logic signed [CW-1:0] cf_re(input int k);
    int v;
    v = ((k * 29 + 5) % 251) - 125;
    return CW'(v);
  endfunction

  function automatic logic signed [CW-1:0] cf_im(input int k);
    int v;
    v = ((k * 53 + 17) % 241) - 120;
    return CW'(v);
  endfunction

  logic signed [DW-1:0] s1_re, s1_im, s2_re, s2_im;
  logic signed [PW-1:0] p_rr [TAPS];
  logic signed [PW-1:0] p_ii [TAPS];
  logic signed [PW-1:0] p_ri [TAPS];
  logic signed [PW-1:0] p_ir [TAPS];
  logic signed [QW-1:0] q_re [TAPS];
  logic signed [QW-1:0] q_im [TAPS];
  logic signed [AW-1:0] a_re [TAPS];
  logic signed [AW-1:0] a_im [TAPS];
  logic [NW-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_re <= '0; s1_im <= '0; s2_re <= '0; s2_im <= '0;
    end else begin
      s1_re <= rx_re; s1_im <= rx_im;
      s2_re <= s1_re; s2_im <= s1_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < TAPS; j++) begin
        p_rr[j] <= '0; p_ii[j] <= '0; p_ri[j] <= '0; p_ir[j] <= '0;
        q_re[j] <= '0; q_im[j] <= '0;
      end
    end else begin
      for (int j = 0; j < TAPS; j++) begin
        p_rr[j] <= PW'(s2_re) * PW'(cf_re(j));
        p_ii[j] <= PW'(s2_im) * PW'(cf_im(j));
        p_ri[j] <= PW'(s2_re) * PW'(cf_im(j));
        p_ir[j] <= PW'(s2_im) * PW'(cf_re(j));
        q_re[j] <= QW'(p_rr[j]) - QW'(p_ii[j]);
        q_im[j] <= QW'(p_ri[j]) + QW'(p_ir[j]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < TAPS; j++) begin
        a_re[j] <= '0; a_im[j] <= '0;
      end
    end else begin
      a_re[0] <= AW'(q_re[0]);
      a_im[0] <= AW'(q_im[0]);
      for (int j = 1; j < TAPS; j++) begin
        a_re[j] <= a_re[j-1] + AW'(q_re[j]);
        a_im[j] <= a_im[j-1] + AW'(q_im[j]);
      end
    end
  end

  assign corr_re = a_re[TAPS-1];
  assign corr_im = a_im[TAPS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt   <= '0;
      corr_valid <= 1'b0;
    end else begin
      if (fill_cnt != NW'(FILL)) fill_cnt <= fill_cnt + 1'b1;
      corr_valid <= (fill_cnt == NW'(FILL)) || corr_valid;
    end
  end

  generate
    if (MAG_EN) begin : g_mag
      logic signed [MW-1:0] sq_re, sq_im;
      assign sq_re = MW'(corr_re) * MW'(corr_re);
      assign sq_im = MW'(corr_im) * MW'(corr_im);
      always_ff @(posedge clk) begin
        if (rst) begin
          mag       <= '0;
          mag_valid <= 1'b0;
        end else begin
          mag       <= $unsigned(sq_re + sq_im);
          mag_valid <= corr_valid;
        end
      end
    end else begin : g_nomag
      assign mag       = '0;
      assign mag_valid = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/preamble_xcorr_chk.sv
module preamble_xcorr_chk #(
  parameter int TAPS   = 64,
  parameter int AW     = 20,
  parameter int MW     = 40,
  parameter bit MAG_EN = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic signed [AW-1:0] corr_re,
  input logic signed [AW-1:0] corr_im,
  input logic                 corr_valid,
  input logic        [MW-1:0] mag,
  input logic                 mag_valid
);
  localparam int FILL = TAPS + 3;
  localparam int KW   = $clog2(FILL + 2) + 1;
  logic [KW-1:0] ck;

  always_ff @(posedge clk) begin
    if (rst) ck <= '0;
    else if (ck != KW'(FILL + 1)) ck <= ck + 1'b1;
  end

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!corr_valid && !mag_valid && corr_re == '0 && corr_im == '0));

  // R4
  valid_early_chk: assert property (@(posedge clk) disable iff (rst)
    (ck <= KW'(FILL)) |-> !corr_valid);

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(corr_valid) |-> (ck == KW'(FILL + 1)));

  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    corr_valid |=> corr_valid);

  generate
    if (MAG_EN) begin : g_mag_chk
      // R5
      mag_follow_chk: assert property (@(posedge clk) disable iff (rst)
        corr_valid |=> mag_valid);
      // R5
      mag_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !corr_valid |=> !mag_valid);
      // R5
      mag_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mag_valid && mag == '0) |-> ($past(corr_re) == '0 && $past(corr_im) == '0));
    end
  endgenerate
endmodule

bind preamble_xcorr preamble_xcorr_chk #(
  .TAPS(TAPS), .AW(AW), .MW(MW), .MAG_EN(MAG_EN)
) chk_i (
  .clk(clk), .rst(rst), .corr_re(corr_re), .corr_im(corr_im),
  .corr_valid(corr_valid), .mag(mag), .mag_valid(mag_valid)
);

// File: tb/preamble_xcorr_tb_top.sv
`timescale 1ns/1ps
module preamble_xcorr_tb_top;
  localparam int T  = 8;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int AW = DW + CW + 1 + $clog2(T);
  localparam int MW = 2 * AW;
  localparam int NS = 24;
  localparam int STIM [NS][2] = '{
    '{ 12, -7}, '{-45, 33}, '{ 90,  1}, '{-128, 127}, '{ 3, -3}, '{ 64, 64},
    '{-1, -1}, '{ 17, -99}, '{ 100, -100}, '{-60, 22}, '{ 0, 55}, '{ 77, 0},
    '{-33, -88}, '{ 127, 127}, '{-128, -128}, '{ 5, 9}, '{-14, 71}, '{ 39, -40},
    '{ 8, 8}, '{-90, 13}, '{ 26, -127}, '{ 111, 45}, '{-7, -66}, '{ 50, -2}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DW-1:0] rx_re = '0, rx_im = '0;
  logic signed [AW-1:0] corr_re, corr_im;
  logic corr_valid, mag_valid;
  logic [MW-1:0] mag;

  always #10 clk = ~clk;

  preamble_xcorr #(.TAPS(T), .DW(DW), .CW(CW), .MAG_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .rx_re(rx_re), .rx_im(rx_im),
    .corr_re(corr_re), .corr_im(corr_im), .corr_valid(corr_valid),
    .mag(mag), .mag_valid(mag_valid));

  int n_chk = 0, n_fail = 0, nk = 0;
  int hr [256];
  int hi [256];
  longint prev_re = 0, prev_im = 0;

  function automatic int c_re(input int k);
    return ((k * 29 + 5) % 251) - 125;
  endfunction
  function automatic int c_im(input int k);
    return ((k * 53 + 17) % 241) - 120;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_after(input int k, input string tag);
    longint er, ei, xr, xi;
    if (k >= T + 3) begin
      er = 0; ei = 0;
      for (int j = 0; j < T; j++) begin
        xr = hr[k - 4 - (T - 1) + j];
        xi = hi[k - 4 - (T - 1) + j];
        er += xr * c_re(j) - xi * c_im(j);
        ei += xr * c_im(j) + xi * c_re(j);
      end
      chk(corr_valid == 1'b1, "R4 valid", longint'(corr_valid), 1);
      chk(longint'(corr_re) == er, {tag, " R2 R3 re"}, longint'(corr_re), er);
      chk(longint'(corr_im) == ei, {tag, " R2 R3 im"}, longint'(corr_im), ei);
      if (k >= T + 4) begin
        chk(mag_valid == 1'b1, "R5 mag_valid", longint'(mag_valid), 1);
        chk(longint'(mag) == prev_re * prev_re + prev_im * prev_im, "R5 mag",
            longint'(mag), prev_re * prev_re + prev_im * prev_im);
      end else begin
        chk(mag_valid == 1'b0, "R5 mag_valid low", longint'(mag_valid), 0);
      end
      prev_re = er; prev_im = ei;
    end else begin
      chk(corr_valid == 1'b0, "R4 not yet valid", longint'(corr_valid), 0);
    end
  endtask

  task automatic push(input int re, input int im, input string tag);
    rx_re = DW'(re); rx_im = DW'(im);
    hr[nk] = re; hi[nk] = im;
    @(posedge clk);
    @(negedge clk);
    check_after(nk, tag);
    nk++;
  endtask

  task automatic do_reset();
    rst = 1'b1; rx_re = '0; rx_im = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(corr_valid == 1'b0 && mag_valid == 1'b0, "R7 valids cleared",
        longint'({corr_valid, mag_valid}), 0);
    chk(corr_re == '0 && corr_im == '0, "R7 sums cleared", longint'(corr_re), 0);
    rst = 1'b0; nk = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NS; i++) push(STIM[i][0], STIM[i][1], "table");

    do_reset();
    push(1, 0, "R8 impulse");
    for (int i = 0; i < T + 6; i++) push(0, 0, "R8 impulse");
    do_reset();
    for (int i = 0; i < T - 1; i++) push(0, 0, "R1");
    push(1, 0, "R1");
    for (int i = 0; i < 3; i++) push(0, 0, "R1");
    for (int j = T - 1; j >= 0; j--) begin
      push(0, 0, "R1");
      chk(longint'(corr_re) == c_re(j), "R1 R8 coef re", longint'(corr_re), c_re(j));
      chk(longint'(corr_im) == c_im(j), "R1 R8 coef im", longint'(corr_im), c_im(j));
    end

    do_reset();
    for (int i = 0; i < T + 6; i++) push(-128, -128, "R6 full scale neg");
    for (int i = 0; i < T + 6; i++) push((i % 2) ? 127 : -128, (i % 2) ? -128 : 127, "R6 mixed");

    for (int i = 0; i < 5; i++) push(STIM[i][0], STIM[i][1], "R7 pre");
    do_reset();
    for (int i = 0; i < T + 2; i++) begin
      push(STIM[i + 5][0], STIM[i + 5][1], "R7 refill");
      chk(corr_valid == 1'b0, "R7 no stale valid", longint'(corr_valid), 0);
    end
    for (int i = 0; i < T; i++) push(STIM[i + 10][0], STIM[i + 10][1], "R7 refill");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule